// File: doc/BRIEF.md
# Dual asynchronous SRAM controller

This block is a synchronous front end for two external 256K x 16 asynchronous SRAM devices. The two devices share one 18-bit address bus and one pair of write and output strobes (both active low). Each device has its own active-low chip enable and its own active-low enables for the high and low byte of its 16-bit word. The block takes one single-beat read or write request at a time, with a four-bit byte mask. It sequences the external strobes so that address, enables and data are stable around every write pulse and during every read. It drives each device's data bus through separate output, output-enable and input signals, which a pad ring outside this block combines into the bidirectional pins. Read data comes back with a one-cycle valid flag.

A mode input is sampled when a request is accepted. In wide mode the two devices answer together as one 32-bit word: device 0 holds bits 15:0 and device 1 holds bits 31:16. In split mode each device is an independent 16-bit memory, and a device-select bit chooses which one the request addresses. The strobe timing is set by two parameters: the number of cycles the write strobe stays low and the number of cycles a read waits before it samples data. Choose them for the clock period so that each access meets the devices' 10 ns access time.

Top module: `sram_pair_ctrl`

## Requirements
- R1: After reset, and in every cycle without an access in progress, both chip enables, both pairs of byte enables, the write strobe and the output strobe are high, no data bus is driven, and `busy` is low.
- R2: A request is accepted on a clock edge where `req_valid` is high and `busy` is low. Its address appears on `mem_addr` after that edge and stays unchanged until the access completes.
- R3: A write lasts WR_PULSE+2 cycles. In the first cycle the write strobe is high and the data is driven. The write strobe is then low for exactly WR_PULSE cycles. In the last cycle it is high again, with the chip enable still low and the data still driven. The output strobe stays high throughout.
- R4: A read holds the output strobe low and the write strobe high for RD_WAIT cycles, with both data buses released. The data is sampled on the edge that ends the last of those cycles, and `rd_valid` is high for exactly the one cycle after that edge.
- R5: In wide mode both chip enables are low during the access. Mask bit 0 enables device 0's low byte, bit 1 device 0's high byte, bit 2 device 1's low byte and bit 3 device 1's high byte (each enable active low). Write data bits 15:0 go to device 0 and bits 31:16 to device 1, and read data is assembled the same way.
- R6: In split mode only the chip enable of the device chosen by `req_dev` (0 or 1) is low. Mask bits 0 and 1 drive that device's low and high byte enables, and the other device's byte enables stay high. Write data bits 15:0 go to the chosen device, and `rd_data[31:16]` reads as zero.
- R7: Any byte of `rd_data` whose mask bit was clear at acceptance reads as zero, whatever the device returns on that lane.
- R8: `busy` is high from the accepting edge until the access completes, and a request presented while `busy` is high is ignored: it causes no strobe and no change of address.
- R9: The write strobe and the output strobe are never low in the same cycle. While the write strobe is low, exactly the enabled devices have their data buses driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_wide | input | 1 | 1: one 32-bit memory, 0: two 16-bit memories (sampled at acceptance) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1: write, 0: read |
| req_dev | input | 1 | Device chosen in split mode |
| req_addr | input | ADDR_W | Word address |
| req_mask | input | 4 | Byte mask, active high |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 32 | Read data |
| mem_addr | output | ADDR_W | Shared address bus |
| mem_we_n | output | 1 | Shared write strobe, active low |
| mem_oe_n | output | 1 | Shared output strobe, active low |
| mem_ce_n | output | 2 | Chip enables, bit d for device d, active low |
| mem_ub_n | output | 2 | High byte enables, bit d for device d, active low |
| mem_lb_n | output | 2 | Low byte enables, bit d for device d, active low |
| mem0_dq_o | output | 16 | Device 0 data out |
| mem0_dq_oe | output | 1 | Device 0 data bus drive enable |
| mem0_dq_i | input | 16 | Device 0 data in |
| mem1_dq_o | output | 16 | Device 1 data out |
| mem1_dq_oe | output | 1 | Device 1 data bus drive enable |
| mem1_dq_i | input | 16 | Device 1 data in |

## Verification
Some rules are checked on every cycle: the pins are quiet whenever no access is in progress, the address does not move during an access, the write and output strobes never overlap, the bus is driven under every write pulse, the chip enables are correct for the mode, the sequencer counters stay in bounds, and the read-valid pulse is single. What the rules cannot show is that the data reaches the right place. That needs the bench's scenarios: a pin-level model of the two devices stores whatever the write pulses deliver, and a separate shadow built from the request semantics predicts every read. Together they expose any lane swap, mask mapping error or wrongly placed data, and they confirm that a request ignored while busy leaves the memory untouched.

// File: rtl/sram_pair_pkg.sv
package sram_pair_pkg;

  localparam int DEV_W  = 16;
  localparam int LANES  = 2;
  localparam int MASK_W = 2 * LANES;
  localparam int DATA_W = DEV_W * LANES;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_WSETUP = 3'd1,
    PH_WPULSE = 3'd2,
    PH_WHOLD  = 3'd3,
    PH_READ   = 3'd4
  } phase_e;

  typedef struct packed {
    logic [LANES-1:0] ce_n;
    logic [LANES-1:0] ub_n;
    logic [LANES-1:0] lb_n;
  } sel_t;

  // Chip and byte enables for a request (active low).
  function automatic sel_t lane_select(input logic wide, input logic dev,
                                       input logic [MASK_W-1:0] mask);
    sel_t s;
    if (wide) begin
      s.ce_n = 2'b00;
      s.lb_n = {~mask[2], ~mask[0]};
      s.ub_n = {~mask[3], ~mask[1]};
    end else begin
      s.ce_n = dev ? 2'b01 : 2'b10;
      s.lb_n = dev ? {~mask[0], 1'b1} : {1'b1, ~mask[0]};
      s.ub_n = dev ? {~mask[1], 1'b1} : {1'b1, ~mask[1]};
    end
    return s;
  endfunction

  // Per-device write words, device 1 in the upper half.
  function automatic logic [DATA_W-1:0] lane_wdata(input logic wide,
                                                   input logic [DATA_W-1:0] wd);
    return wide ? wd : {wd[DEV_W-1:0], wd[DEV_W-1:0]};
  endfunction

  function automatic logic [DEV_W-1:0] byte_keep(input logic hi, input logic lo);
    return {{8{hi}}, {8{lo}}};
  endfunction

  // Merge device words into a read result, zeroing unselected bytes.
  function automatic logic [DATA_W-1:0] lane_rdata(input logic wide, input logic dev,
                                                   input logic [MASK_W-1:0] mask,
                                                   input logic [DEV_W-1:0] d0,
                                                   input logic [DEV_W-1:0] d1);
    logic [DEV_W-1:0] pick;
    if (wide)
      return {d1 & byte_keep(mask[3], mask[2]), d0 & byte_keep(mask[1], mask[0])};
    pick = dev ? d1 : d0;
    return {{DEV_W{1'b0}}, pick & byte_keep(mask[1], mask[0])};
  endfunction

endpackage

// File: rtl/sram_pair_seq.sv
module sram_pair_seq
  import sram_pair_pkg::*;
#(
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_wr,
  output phase_e phase_q,
  output phase_e phase_d,
  output logic   rd_strobe
);

  localparam int CNT_MAX = (RD_WAIT > WR_PULSE) ? RD_WAIT : WR_PULSE;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_WAIT - 1);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(WR_PULSE - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        cnt_d = '0;
        if (start) phase_d = start_wr ? PH_WSETUP : PH_READ;
      end
      PH_WSETUP: begin
        phase_d = PH_WPULSE;
        cnt_d   = '0;
      end
      PH_WPULSE: begin
        if (cnt_q == WR_LAST) begin
          phase_d = PH_WHOLD;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_WHOLD: phase_d = PH_IDLE;
      PH_READ: begin
        if (cnt_q == RD_LAST) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign rd_strobe = (phase_q == PH_READ) && (cnt_q == RD_LAST);

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WPULSE) |-> (cnt_q <= WR_LAST)); // R3
  AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READ) |-> (cnt_q <= RD_LAST)); // R4
  AST_READ_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> (phase_q == PH_IDLE)); // R4

endmodule

// File: rtl/sram_pair_pins.sv
module sram_pair_pins
  import sram_pair_pkg::*;
#(
  parameter int ADDR_W = 18
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  phase_e                      phase_d,
  input  logic                        load,
  input  sel_t                        sel_in,
  input  logic [ADDR_W-1:0]           addr_in,
  input  logic [LANES-1:0][DEV_W-1:0] wdata_in,
  output logic [ADDR_W-1:0]           addr,
  output logic [LANES-1:0]            ce_n,
  output logic [LANES-1:0]            ub_n,
  output logic [LANES-1:0]            lb_n,
  output logic                        we_n,
  output logic                        oe_n,
  output logic [LANES-1:0]            dq_oe,
  output logic [LANES-1:0][DEV_W-1:0] dq_o
);

  sel_t sel_q, sel_src;
  assign sel_src = load ? sel_in : sel_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      sel_q <= '1;
      ce_n  <= '1;
      ub_n  <= '1;
      lb_n  <= '1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= '0;
    end else begin
      if (load) begin
        addr  <= addr_in;
        sel_q <= sel_in;
      end
      unique case (phase_d)
        PH_WSETUP, PH_WHOLD, PH_WPULSE: begin
          ce_n  <= sel_src.ce_n;
          ub_n  <= sel_src.ub_n;
          lb_n  <= sel_src.lb_n;
          we_n  <= (phase_d != PH_WPULSE);
          oe_n  <= 1'b1;
          dq_oe <= ~sel_src.ce_n;
        end
        PH_READ: begin
          ce_n  <= sel_src.ce_n;
          ub_n  <= sel_src.ub_n;
          lb_n  <= sel_src.lb_n;
          we_n  <= 1'b1;
          oe_n  <= 1'b0;
          dq_oe <= '0;
        end
        default: begin
          ce_n  <= '1;
          ub_n  <= '1;
          lb_n  <= '1;
          we_n  <= 1'b1;
          oe_n  <= 1'b1;
          dq_oe <= '0;
        end
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)    dq_o[g] <= '0;
      else if (load) dq_o[g] <= wdata_in[g];
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n)); // R9
  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (dq_oe == ~ce_n)); // R9
  AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (dq_oe == '0)); // R4
  AST_WE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ((ce_n != '1) && (dq_oe != '0))); // R3

endmodule

// File: rtl/sram_pair_ctrl.sv
module sram_pair_ctrl
  import sram_pair_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int RD_WAIT  = 2,
  parameter int WR_PULSE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_dev,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_mask,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [1:0]        mem_ce_n,
  output logic [1:0]        mem_ub_n,
  output logic [1:0]        mem_lb_n,
  output logic [15:0]       mem0_dq_o,
  output logic              mem0_dq_oe,
  input  logic [15:0]       mem0_dq_i,
  output logic [15:0]       mem1_dq_o,
  output logic              mem1_dq_oe,
  input  logic [15:0]       mem1_dq_i
);

  phase_e phase_q, phase_d;
  logic   rd_strobe;
  logic   accept;
  logic   mode_q, dev_q;
  logic [MASK_W-1:0] mask_q;
  logic [LANES-1:0][DEV_W-1:0] wlanes, dq_o_w;
  logic [LANES-1:0] dq_oe_w;

  assign busy   = (phase_q != PH_IDLE);
  assign accept = req_valid && !busy;
  assign wlanes = lane_wdata(mode_wide, req_wdata);

  sram_pair_seq #(.RD_WAIT(RD_WAIT), .WR_PULSE(WR_PULSE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .start_wr (req_write),
    .phase_q  (phase_q),
    .phase_d  (phase_d),
    .rd_strobe(rd_strobe)
  );

  sram_pair_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_d (phase_d),
    .load    (accept),
    .sel_in  (lane_select(mode_wide, req_dev, req_mask)),
    .addr_in (req_addr),
    .wdata_in(wlanes),
    .addr    (mem_addr),
    .ce_n    (mem_ce_n),
    .ub_n    (mem_ub_n),
    .lb_n    (mem_lb_n),
    .we_n    (mem_we_n),
    .oe_n    (mem_oe_n),
    .dq_oe   (dq_oe_w),
    .dq_o    (dq_o_w)
  );

  assign mem0_dq_o  = dq_o_w[0];
  assign mem1_dq_o  = dq_o_w[1];
  assign mem0_dq_oe = dq_oe_w[0];
  assign mem1_dq_oe = dq_oe_w[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      dev_q    <= 1'b0;
      mask_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (accept) begin
        mode_q <= mode_wide;
        dev_q  <= req_dev;
        mask_q <= req_mask;
      end
      rd_valid <= rd_strobe;
      if (rd_strobe)
        rd_data <= lane_rdata(mode_q, dev_q, mask_q, mem0_dq_i, mem1_dq_i);
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mem_ce_n == 2'b11 && mem_we_n && mem_oe_n && dq_oe_w == '0)); // R1
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr)); // R2
  AST_WIDE_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |-> (mem_ce_n == 2'b00)); // R5
  AST_SPLIT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |-> ($countones(~mem_ce_n) == 1)); // R6
  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R4
  AST_RDV_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !busy); // R8

endmodule

// File: tb/sram_pair_ctrl_tb.sv
module sram_pair_ctrl_tb;

  localparam int RDW = 2;
  localparam int WRP = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wide = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_dev = 1'b0;
  logic [17:0] req_addr = '0;
  logic [3:0]  req_mask = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, rd_valid;
  logic [31:0] rd_data;
  logic [17:0] mem_addr;
  logic        mem_we_n, mem_oe_n;
  logic [1:0]  mem_ce_n, mem_ub_n, mem_lb_n;
  logic [15:0] mem0_dq_o, mem1_dq_o, mem0_dq_i, mem1_dq_i;
  logic        mem0_dq_oe, mem1_dq_oe;

  int n_chk = 0, n_fail = 0, we_pulses = 0;
  bit done = 0;

  logic [15:0] m0 [int];
  logic [15:0] m1 [int];
  logic [15:0] s0 [int];
  logic [15:0] s1 [int];
  logic [17:0] pool [8];

  always #4 clk = ~clk;

  sram_pair_ctrl #(.ADDR_W(18), .RD_WAIT(RDW), .WR_PULSE(WRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .req_valid(req_valid),
    .req_write(req_write), .req_dev(req_dev), .req_addr(req_addr),
    .req_mask(req_mask), .req_wdata(req_wdata), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_addr(mem_addr), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ce_n(mem_ce_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem0_dq_o(mem0_dq_o), .mem0_dq_oe(mem0_dq_oe), .mem0_dq_i(mem0_dq_i),
    .mem1_dq_o(mem1_dq_o), .mem1_dq_oe(mem1_dq_oe), .mem1_dq_i(mem1_dq_i)
  );

  // Pin-level model of the two devices: write latched at the end of the strobe.
  function automatic logic [15:0] merge_bytes(logic [15:0] old, logic [15:0] nw,
                                              logic ub, logic lb);
    logic [15:0] r;
    r = old;
    if (!lb) r[7:0]  = nw[7:0];
    if (!ub) r[15:8] = nw[15:8];
    return r;
  endfunction

  always @(posedge mem_we_n) begin
    int a;
    a = int'(mem_addr);
    if (mem_ce_n[0] === 1'b0 && mem0_dq_oe === 1'b1)
      m0[a] = merge_bytes(m0.exists(a) ? m0[a] : 16'h0, mem0_dq_o, mem_ub_n[0], mem_lb_n[0]);
    if (mem_ce_n[1] === 1'b0 && mem1_dq_oe === 1'b1)
      m1[a] = merge_bytes(m1.exists(a) ? m1[a] : 16'h0, mem1_dq_o, mem_ub_n[1], mem_lb_n[1]);
  end

  always @(negedge mem_we_n) we_pulses++;

  // Read drive; lanes without enable return filler bytes.
  always @(mem_ce_n or mem_oe_n or mem_addr or mem_ub_n or mem_lb_n or mem_we_n) begin
    int a;
    logic [15:0] w;
    a = int'(mem_addr);
    w = m0.exists(a) ? m0[a] : 16'h0;
    mem0_dq_i = (mem_ce_n[0] === 1'b0 && mem_oe_n === 1'b0) ?
      {mem_ub_n[0] ? 8'hEE : w[15:8], mem_lb_n[0] ? 8'hEE : w[7:0]} : 16'hEEEE;
    w = m1.exists(a) ? m1[a] : 16'h0;
    mem1_dq_i = (mem_ce_n[1] === 1'b0 && mem_oe_n === 1'b0) ?
      {mem_ub_n[1] ? 8'hEE : w[15:8], mem_lb_n[1] ? 8'hEE : w[7:0]} : 16'hEEEE;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected enables from the request, lane by lane.
  function automatic logic [5:0] exp_en(bit wide, bit dev, logic [3:0] m);
    logic [1:0] ce, ub, lb;
    for (int d = 0; d < 2; d++) begin
      ce[d] = wide ? 1'b0 : (dev != d[0]);
      lb[d] = ce[d] ? 1'b1 : ~m[wide ? 2*d : 0];
      ub[d] = ce[d] ? 1'b1 : ~m[wide ? 2*d+1 : 1];
    end
    return {ce, ub, lb};
  endfunction

  function automatic logic [31:0] exp_read(bit wide, bit dev, logic [17:0] a, logic [3:0] m);
    logic [31:0] r;
    logic [15:0] w0, w1;
    int k;
    k  = int'(a);
    w0 = s0.exists(k) ? s0[k] : 16'h0;
    w1 = s1.exists(k) ? s1[k] : 16'h0;
    r = '0;
    if (wide) begin
      for (int b = 0; b < 4; b++)
        if (m[b]) r[8*b +: 8] = (b < 2) ? w0[8*(b%2) +: 8] : w1[8*(b%2) +: 8];
    end else begin
      for (int b = 0; b < 2; b++)
        if (m[b]) r[8*b +: 8] = dev ? w1[8*b +: 8] : w0[8*b +: 8];
    end
    return r;
  endfunction

  task automatic shadow_write(bit wide, bit dev, logic [17:0] a, logic [3:0] m, logic [31:0] wd);
    int k;
    logic [15:0] w0, w1;
    k  = int'(a);
    w0 = s0.exists(k) ? s0[k] : 16'h0;
    w1 = s1.exists(k) ? s1[k] : 16'h0;
    for (int b = 0; b < 4; b++) begin
      if (wide && m[b]) begin
        if (b < 2) w0[8*b +: 8] = wd[8*b +: 8];
        else       w1[8*(b-2) +: 8] = wd[8*b +: 8];
      end else if (!wide && b < 2 && m[b]) begin
        if (dev) w1[8*b +: 8] = wd[8*b +: 8];
        else     w0[8*b +: 8] = wd[8*b +: 8];
      end
    end
    s0[k] = w0;
    s1[k] = w1;
  endtask

  task automatic idle_chk(string tag);
    chk({tag, " R1 ce"}, {30'd0, mem_ce_n}, 32'd3);
    chk({tag, " R1 strobes"}, {30'd0, mem_we_n, mem_oe_n}, 32'd3);
    chk({tag, " R1 drive"}, {30'd0, mem1_dq_oe, mem0_dq_oe}, 32'd0);
    chk({tag, " R1 busy"}, {31'd0, busy}, 32'd0);
  endtask

  // Called at a falling edge; checks every cycle of the access.
  task automatic do_op(bit wr, bit wide, bit dev, logic [17:0] a, logic [3:0] m,
                       logic [31:0] wd, bit poke);
    logic [5:0] en;
    int pulses0, last;
    en = exp_en(wide, dev, m);
    pulses0 = we_pulses;
    mode_wide = wide; req_write = wr; req_dev = dev; req_addr = a;
    req_mask = m; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    last = wr ? WRP + 2 : RDW + 1;
    for (int c = 0; c <= last; c++) begin
      if (poke && c == 1) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = ~a; req_wdata = ~wd;
      end
      if (poke && c == 2) req_valid = 1'b0;
      if (wr) begin
        if (c <= WRP + 1) begin
          chk("R8 busy during write", {31'd0, busy}, 32'd1);
          chk("R2 address held", {14'd0, mem_addr}, {14'd0, a});
          chk(wide ? "R5 enables" : "R6 enables", {26'd0, mem_ce_n, mem_ub_n, mem_lb_n}, {26'd0, en});
          chk("R3 write strobe", {31'd0, mem_we_n}, (c >= 1 && c <= WRP) ? 32'd0 : 32'd1);
          chk("R3 output strobe high", {31'd0, mem_oe_n}, 32'd1);
          chk("R9 drive under write", {30'd0, mem1_dq_oe, mem0_dq_oe}, {30'd0, ~en[5:4]});
          if (!en[4]) chk(wide ? "R5 dev0 data" : "R6 dev0 data", {16'd0, mem0_dq_o}, {16'd0, wd[15:0]});
          if (!en[5]) chk(wide ? "R5 dev1 data" : "R6 dev1 data", {16'd0, mem1_dq_o},
                          {16'd0, wide ? wd[31:16] : wd[15:0]});
        end else begin
          idle_chk("after write");
        end
      end else begin
        if (c < RDW) begin
          chk("R8 busy during read", {31'd0, busy}, 32'd1);
          chk("R2 address held", {14'd0, mem_addr}, {14'd0, a});
          chk(wide ? "R5 enables" : "R6 enables", {26'd0, mem_ce_n, mem_ub_n, mem_lb_n}, {26'd0, en});
          chk("R4 strobes", {30'd0, mem_we_n, mem_oe_n}, 32'd2);
          chk("R4 bus released", {30'd0, mem1_dq_oe, mem0_dq_oe}, 32'd0);
          chk("R4 no early valid", {31'd0, rd_valid}, 32'd0);
        end else if (c == RDW) begin
          chk("R4 valid pulse", {31'd0, rd_valid}, 32'd1);
          chk(wide ? "R5 R7 read data" : "R6 R7 read data", rd_data, exp_read(wide, dev, a, m));
          idle_chk("after read");
        end else begin
          chk("R4 valid single", {31'd0, rd_valid}, 32'd0);
        end
      end
      @(negedge clk);
    end
    if (wr) begin
      chk("R8 one strobe per write", we_pulses, pulses0 + 1);
      shadow_write(wide, dev, a, m, wd);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    pool[0] = 18'h00000;
    pool[1] = 18'h3FFFF;
    for (int i = 2; i < 8; i++) pool[i] = 18'($urandom);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("reset");
    chk("R4 reset valid", {31'd0, rd_valid}, 32'd0);

    // Directed: wide write and readback, full then partial masks.
    do_op(1, 1, 0, pool[1], 4'hF, 32'hA1B2C3D4, 0);
    do_op(0, 1, 0, pool[1], 4'hF, 32'h0, 0);
    do_op(0, 1, 0, pool[1], 4'b0101, 32'h0, 0);   // R7 zeroed bytes
    do_op(1, 1, 0, pool[1], 4'b1000, 32'h5Fxxxxxx & 32'h5F000000, 0);
    do_op(0, 1, 0, pool[1], 4'hF, 32'h0, 0);
    // Split: device 1 only, device 0 untouched at same address.
    do_op(1, 0, 1, pool[0], 4'b11, 32'h0000BEEF, 0);
    do_op(0, 0, 1, pool[0], 4'b11, 32'h0, 0);
    do_op(0, 0, 0, pool[0], 4'b11, 32'h0, 0);
    do_op(1, 0, 0, pool[0], 4'b01, 32'hFFFF1234, 0);
    do_op(0, 1, 0, pool[0], 4'hF, 32'h0, 0);
    // R8: request during busy ignored, its address stays unwritten.
    do_op(1, 1, 0, pool[2], 4'hF, 32'h13579BDF, 1);
    do_op(0, 1, 0, ~pool[2], 4'hF, 32'h0, 0);
    do_op(0, 1, 0, pool[2], 4'hF, 32'h0, 0);

    for (int i = 0; i < 400; i++) begin
      bit wr, wide, dev;
      wr   = 1'($urandom);
      wide = 1'($urandom);
      dev  = 1'($urandom);
      do_op(wr, wide, dev, pool[$urandom % 8], 4'($urandom), $urandom, 0);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule